// File: doc/BRIEF.md
# Tranche Loss Mapping Accumulator

This block turns a stream of collateral-pool loss samples into losses borne by a single tranche, and sums those tranche losses over many Monte-Carlo paths. Each sample carries a time-step index and a flag that marks the final sample of a path. The tranche is set by two configuration values, a lower loss threshold (attach) and an upper loss threshold (detach). Each pool loss is clamped into the window between them. The result is added to one wide accumulator per time step. The mapped loss and the still-outstanding tranche amount are also presented for every accepted sample.

When all paths have been fed in, software asks for a read-out. The block then steps through the time-step accumulators in index order over a valid/ready handshake, and shows the number of completed paths alongside each sum. Software does the division to an average, the discounting and the valuation of the legs. A clear command resets the sums and the path count for the next run. The default widths are 42-bit losses and 54-bit sums, which give the accuracy of double-precision accumulation.

Top module: `tl_accum`

## Requirements
- R1: A sample whose pool loss is less than or equal to attach gives a mapped loss (`map_loss`) of zero, one cycle after it is accepted (`map_valid` high).
- R2: A sample whose pool loss is greater than or equal to detach gives a mapped loss equal to the tranche width, detach minus attach.
- R3: A sample whose pool loss lies strictly between attach and detach gives a mapped loss of pool loss minus attach. Example: with attach 300 and detach 600, a loss of 400 maps to 100.
- R4: `map_remaining` equals the tranche width minus the mapped loss for the same sample.
- R5: Each accepted sample adds its mapped loss to the accumulator selected by `in_step`. A read-out started by `rd_req` in the idle state presents steps 0, 1, … STEPS-1 in that order, one step per accepted handshake, with `rd_last` high on step STEPS-1. The block then returns to idle.
- R6: The path count (`rd_paths`) increases by one for every accepted sample that has `in_last` high.
- R7: A configuration write (`cfg_we`) takes effect only while idle, meaning no path is open and no read-out is running. A write at any other time leaves attach and detach unchanged.
- R8: After reset, and after `clear` is given while idle, every accumulator and the path count read zero.
- R9: When detach is not greater than attach, `cfg_invalid` is high and every mapped loss and remaining amount is zero.
- R10: The read-out does not change the stored sums, so a second read-out returns the same values. While `rd_ready` is low, `rd_step` and `rd_sum` hold steady.
- R11: During a read-out `in_ready` is low, and samples offered then are not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write attach/detach (honoured when idle) |
| cfg_attach | input | LOSS_W | Attach threshold |
| cfg_detach | input | LOSS_W | Detach threshold |
| cfg_invalid | output | 1 | Detach not above attach |
| clear | input | 1 | Zero sums and path count (honoured when idle) |
| in_valid | input | 1 | Pool-loss sample present |
| in_ready | output | 1 | Samples accepted (low during read-out) |
| in_step | input | IDX_W | Time-step index of the sample |
| in_loss | input | LOSS_W | Pool loss |
| in_last | input | 1 | Final sample of a path |
| map_valid | output | 1 | Mapped result of the previous accepted sample |
| map_loss | output | LOSS_W | Tranche loss of that sample |
| map_remaining | output | LOSS_W | Outstanding tranche amount of that sample |
| rd_req | input | 1 | Start a read-out (idle, no sample offered) |
| rd_valid | output | 1 | Read-out word present |
| rd_ready | input | 1 | Consumer takes the word |
| rd_step | output | IDX_W | Time step of the word |
| rd_sum | output | ACC_W | Accumulated tranche loss of that step |
| rd_last | output | 1 | Final step of the read-out |
| rd_paths | output | CNT_W | Completed path count |

## Verification
The bench builds the block with STEPS=4, LOSS_W=16, ACC_W=24 and CNT_W=8. With four steps, a whole read-out fits in a few cycles, so the bench can scan it repeatedly: with and without stalls, before and after a clear, and during an attempt to inject samples. The 16-bit losses let hand-picked values fall exactly on attach, on detach, between them and at the all-ones extreme. The bench also uses zero-width and full-range windows.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_READ = 2'd2
    } tl_state_e;

    typedef struct packed {
        logic acc_en;
        logic path_end;
        logic clr;
        logic cfg_en;
    } tl_ctl_s;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tl_clamp.sv
module tl_clamp #(
    parameter int unsigned LOSS_W = 42
) (
    input  logic [LOSS_W-1:0] loss,
    input  logic [LOSS_W-1:0] att,
    input  logic [LOSS_W-1:0] det,
    output logic              invalid,
    output logic [LOSS_W-1:0] tloss,
    output logic [LOSS_W-1:0] remaining
);
    logic [LOSS_W-1:0] width;

    always_comb begin
        invalid = (det <= att);
        width   = invalid ? '0 : det - att;
        if (invalid || loss <= att)
            tloss = '0;
        else if (loss >= det)
            tloss = width;
        else
            tloss = loss - att;
        remaining = width - tloss;
    end
endmodule

// File: rtl/tl_acc_bank.sv
module tl_acc_bank #(
    parameter int unsigned STEPS  = 16,
    parameter int unsigned LOSS_W = 42,
    parameter int unsigned ACC_W  = 54,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [IDX_W-1:0]  add_idx,
    input  logic [LOSS_W-1:0] add_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ACC_W-1:0]  rd_sum
);
    localparam int unsigned PAD_W = ACC_W - LOSS_W;

    logic [ACC_W-1:0] acc_q [STEPS];
    logic [ACC_W-1:0] add_ext;

    assign add_ext = {{PAD_W{1'b0}}, add_val};

    for (genvar g = 0; g < STEPS; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst || clr)
                acc_q[g] <= '0;
            else if (add_en && add_idx == IDX_W'(g))
                acc_q[g] <= acc_q[g] + add_ext;
        end
    end

    assign rd_sum = acc_q[rd_idx];
endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl
    import tl_pkg::*;
#(
    parameter int unsigned STEPS = 16,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             cfg_we,
    input  logic             clear,
    input  logic             rd_req,
    input  logic             rd_ready,
    output tl_ctl_s          ctl,
    output logic             in_ready,
    output logic             idle,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rd_last,
    output logic [CNT_W-1:0] paths
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    tl_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             accept;

    assign in_ready = (state_q != ST_READ);
    assign idle     = (state_q == ST_IDLE);
    assign rd_valid = (state_q == ST_READ);
    assign rd_idx   = idx_q;
    assign rd_last  = rd_valid && (idx_q == LAST_IDX);

    always_comb begin
        accept       = in_valid && in_ready;
        ctl.clr      = clear && idle;
        ctl.cfg_en   = cfg_we && idle;
        ctl.acc_en   = accept && !ctl.clr;
        ctl.path_end = accept && in_last;
        state_d      = state_q;
        idx_d        = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = in_last ? ST_IDLE : ST_RUN;
                else if (rd_req && !clear) begin
                    state_d = ST_READ;
                    idx_d   = '0;
                end
            end
            ST_RUN: begin
                if (accept && in_last)
                    state_d = ST_IDLE;
            end
            ST_READ: begin
                if (rd_ready) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)
            paths <= '0;
        else if (ctl.path_end)
            paths <= paths + 1'b1;
    end
endmodule

// File: rtl/tl_accum.sv
module tl_accum
    import tl_pkg::*;
#(
    parameter int unsigned STEPS  = 16,
    parameter int unsigned LOSS_W = 42,
    parameter int unsigned ACC_W  = 54,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned IDX_W = idx_bits(STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [LOSS_W-1:0] cfg_attach,
    input  logic [LOSS_W-1:0] cfg_detach,
    output logic              cfg_invalid,
    input  logic              clear,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_step,
    input  logic [LOSS_W-1:0] in_loss,
    input  logic              in_last,
    output logic              map_valid,
    output logic [LOSS_W-1:0] map_loss,
    output logic [LOSS_W-1:0] map_remaining,
    input  logic              rd_req,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [IDX_W-1:0]  rd_step,
    output logic [ACC_W-1:0]  rd_sum,
    output logic              rd_last,
    output logic [CNT_W-1:0]  rd_paths
);
    tl_ctl_s           ctl;
    logic              idle;
    logic [LOSS_W-1:0] att_q, det_q;
    logic [LOSS_W-1:0] tloss, trem;

    always_ff @(posedge clk) begin
        if (rst) begin
            att_q <= '0;
            det_q <= '0;
        end else if (ctl.cfg_en) begin
            att_q <= cfg_attach;
            det_q <= cfg_detach;
        end
    end

    tl_clamp #(.LOSS_W(LOSS_W)) u_clamp (
        .loss      (in_loss),
        .att       (att_q),
        .det       (det_q),
        .invalid   (cfg_invalid),
        .tloss     (tloss),
        .remaining (trem)
    );

    tl_ctrl #(.STEPS(STEPS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .cfg_we   (cfg_we),
        .clear    (clear),
        .rd_req   (rd_req),
        .rd_ready (rd_ready),
        .ctl      (ctl),
        .in_ready (in_ready),
        .idle     (idle),
        .rd_valid (rd_valid),
        .rd_idx   (rd_step),
        .rd_last  (rd_last),
        .paths    (rd_paths)
    );

    tl_acc_bank #(.STEPS(STEPS), .LOSS_W(LOSS_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr),
        .add_en  (ctl.acc_en),
        .add_idx (in_step),
        .add_val (tloss),
        .rd_idx  (rd_step),
        .rd_sum  (rd_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            map_valid     <= 1'b0;
            map_loss      <= '0;
            map_remaining <= '0;
        end else begin
            map_valid <= in_valid && in_ready;
            if (in_valid && in_ready) begin
                map_loss      <= tloss;
                map_remaining <= trem;
            end
        end
    end
endmodule

// File: rtl/tl_accum_chk.sv
module tl_accum_chk #(
    parameter int unsigned STEPS  = 16,
    parameter int unsigned LOSS_W = 42,
    parameter int unsigned ACC_W  = 54,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              clear,
    input logic              idle,
    input logic              cfg_invalid,
    input logic [LOSS_W-1:0] att_q,
    input logic [LOSS_W-1:0] det_q,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LOSS_W-1:0] in_loss,
    input logic              in_last,
    input logic              map_valid,
    input logic [LOSS_W-1:0] map_loss,
    input logic [LOSS_W-1:0] map_remaining,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [IDX_W-1:0]  rd_step,
    input logic [ACC_W-1:0]  rd_sum,
    input logic              rd_last,
    input logic [CNT_W-1:0]  rd_paths
);
    logic take;
    assign take = in_valid && in_ready;

    // R1
    below_att_chk: assert property (@(posedge clk) disable iff (rst)
        (take && in_loss <= att_q) |=> (map_valid && map_loss == '0));

    // R2
    above_det_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !cfg_invalid && in_loss >= det_q) |=> (map_loss == $past(det_q - att_q)));

    // R3
    inside_win_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !cfg_invalid && in_loss > att_q && in_loss < det_q)
        |=> (map_loss == $past(in_loss - att_q)));

    // R4
    remain_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !cfg_invalid)
        |=> (LOSS_W'(map_loss + map_remaining) == $past(det_q - att_q)));

    // R5
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && !rd_last) |=> (rd_valid && rd_step == $past(rd_step) + 1'b1));

    // R5
    read_last_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_last) |-> (rd_step == IDX_W'(STEPS - 1)));

    // R6
    path_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (take && in_last && !(clear && idle)) |=> (rd_paths == $past(rd_paths) + 1'b1));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !idle) |=> ($stable(att_q) && $stable(det_q)));

    // R8
    clear_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && idle) |=> (rd_paths == '0));

    // R9
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cfg_invalid) |=> (map_loss == '0 && map_remaining == '0));

    // R10
    read_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_step) && $stable(rd_sum)));

    // R11
    read_block_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !in_ready);
endmodule

bind tl_accum tl_accum_chk #(
    .STEPS(STEPS), .LOSS_W(LOSS_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .clear(clear), .idle(idle),
    .cfg_invalid(cfg_invalid), .att_q(att_q), .det_q(det_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_loss(in_loss), .in_last(in_last),
    .map_valid(map_valid), .map_loss(map_loss), .map_remaining(map_remaining),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_step(rd_step), .rd_sum(rd_sum),
    .rd_last(rd_last), .rd_paths(rd_paths)
);

// File: tb/tl_accum_bench.sv
module tl_accum_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS  = 4;
    localparam int LOSS_W = 16;
    localparam int ACC_W  = 24;
    localparam int CNT_W  = 8;
    localparam int IDX_W  = 2;

    logic clk = 1'b0;
    logic rst, cfg_we, clear, in_valid, in_last, rd_req, rd_ready;
    logic [LOSS_W-1:0] cfg_attach, cfg_detach, in_loss;
    logic [IDX_W-1:0]  in_step;
    logic cfg_invalid, in_ready, map_valid, rd_valid, rd_last;
    logic [LOSS_W-1:0] map_loss, map_remaining;
    logic [IDX_W-1:0]  rd_step;
    logic [ACC_W-1:0]  rd_sum;
    logic [CNT_W-1:0]  rd_paths;

    always #(CLK_PERIOD/2) clk = ~clk;

    tl_accum #(.STEPS(STEPS), .LOSS_W(LOSS_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_tl_accum (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_attach(cfg_attach), .cfg_detach(cfg_detach),
        .cfg_invalid(cfg_invalid), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
        .in_step(in_step), .in_loss(in_loss), .in_last(in_last), .map_valid(map_valid),
        .map_loss(map_loss), .map_remaining(map_remaining), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_step(rd_step), .rd_sum(rd_sum), .rd_last(rd_last), .rd_paths(rd_paths)
    );

    int checks = 0;
    int fails  = 0;
    string phase = "R8";

    // behavioural reference
    longint m_att = 0, m_det = 0, m_paths = 0, m_idx = 0;
    longint m_acc [STEPS];
    int     m_mode = 0;              // 0 idle, 1 path open, 2 reading
    bit     e_map_valid = 0;
    longint e_map_loss = 0, e_map_rem = 0;

    function automatic longint tmap(longint l, longint a, longint d);
        if (d <= a) return 0;
        if (l <= a) return 0;
        if (l >= d) return d - a;
        return l - a;
    endfunction

    task automatic model_step();
        bit accept, idl, clr;
        longint tl, w;
        if (rst) begin
            m_att = 0; m_det = 0; m_paths = 0; m_idx = 0; m_mode = 0;
            foreach (m_acc[i]) m_acc[i] = 0;
            e_map_valid = 0; e_map_loss = 0; e_map_rem = 0;
            return;
        end
        idl    = (m_mode == 0);
        accept = in_valid && (m_mode != 2);
        clr    = clear && idl;
        w      = (m_det <= m_att) ? 0 : m_det - m_att;
        tl     = tmap(longint'(in_loss), m_att, m_det);
        e_map_valid = accept;
        if (accept) begin e_map_loss = tl; e_map_rem = w - tl; end
        if (clr) begin
            foreach (m_acc[i]) m_acc[i] = 0;
            m_paths = 0;
        end else if (accept) begin
            m_acc[in_step] += tl;
            if (in_last) m_paths++;
        end
        if (cfg_we && idl) begin m_att = cfg_attach; m_det = cfg_detach; end
        case (m_mode)
            0: if (accept) m_mode = in_last ? 0 : 1;
               else if (rd_req && !clear) begin m_mode = 2; m_idx = 0; end
            1: if (accept && in_last) m_mode = 0;
            default: if (rd_ready) begin
                if (m_idx == STEPS - 1) begin m_mode = 0; m_idx = 0; end
                else m_idx++;
            end
        endcase
    endtask

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    task automatic compare();
        chk("R11 in_ready", longint'(in_ready), (m_mode != 2) ? 1 : 0);
        chk("R9 cfg_invalid", longint'(cfg_invalid), (m_det <= m_att) ? 1 : 0);
        chk("R6 rd_paths", longint'(rd_paths), m_paths);
        chk("R5 rd_valid", longint'(rd_valid), (m_mode == 2) ? 1 : 0);
        chk("R3 map_valid", longint'(map_valid), longint'(e_map_valid));
        if (e_map_valid) begin
            chk("R1/R2/R3 map_loss", longint'(map_loss), e_map_loss);
            chk("R4 map_remaining", longint'(map_remaining), e_map_rem);
        end
        if (m_mode == 2) begin
            chk("R5 rd_step", longint'(rd_step), m_idx);
            chk("R5 rd_sum", longint'(rd_sum), m_acc[m_idx]);
            chk("R5 rd_last", longint'(rd_last), (m_idx == STEPS - 1) ? 1 : 0);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic cfg(longint a, longint d);
        cfg_we = 1; cfg_attach = LOSS_W'(a); cfg_detach = LOSS_W'(d);
        tick();
        cfg_we = 0;
    endtask

    task automatic sample(int st, longint l, bit last);
        in_valid = 1; in_step = IDX_W'(st); in_loss = LOSS_W'(l); in_last = last;
        tick();
        in_valid = 0; in_last = 0;
    endtask

    task automatic readout(bit stall);
        rd_req = 1; rd_ready = 0;
        tick();
        rd_req = 0;
        for (int k = 0; k < 3 * STEPS && m_mode == 2; k++) begin
            rd_ready = stall ? k[0] : 1'b1;
            tick();
        end
        rd_ready = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1; cfg_we = 0; clear = 0; in_valid = 0; in_last = 0; rd_req = 0; rd_ready = 0;
        cfg_attach = '0; cfg_detach = '0; in_loss = '0; in_step = '0;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R8 reset state: zero sums and path count
        phase = "R8"; readout(1'b0);

        phase = "R3"; cfg(300, 600);
        // R1 below and at attach, R3 inside, R2 at detach
        sample(0, 100, 0); sample(1, 300, 0); sample(2, 400, 0); sample(3, 600, 1);
        phase = "R2";
        sample(0, 0, 0); sample(1, 450, 0); sample(2, 900, 0); sample(3, 65535, 1);

        // R7 configuration write while a path is open is ignored
        phase = "R7";
        sample(0, 500, 0);
        cfg(0, 1000);
        sample(1, 500, 0); sample(2, 200, 1);

        // R5 / R10 stalled read-out, then a second identical one
        phase = "R10"; readout(1'b1);
        readout(1'b0);

        // R11 samples offered during read-out are dropped
        phase = "R11";
        rd_req = 1; tick(); rd_req = 0;
        in_valid = 1; in_step = 1; in_loss = 555; in_last = 1; rd_ready = 0;
        tick(); tick();
        in_valid = 0; in_last = 0;
        for (int k = 0; k < STEPS; k++) begin rd_ready = 1; tick(); end
        rd_ready = 0;
        readout(1'b0);

        // R9 zero-width window
        phase = "R9"; cfg(600, 600);
        sample(2, 700, 0); sample(3, 100, 1);
        cfg(700, 100);
        sample(0, 400, 1);

        // R8 clear while idle
        phase = "R8"; clear = 1; tick(); clear = 0;
        readout(1'b0);

        // R6 path counting with a full-range window
        phase = "R6"; cfg(0, 65535);
        for (int p = 0; p < 5; p++) begin
            for (int s = 0; s < STEPS; s++) sample(s, 1000 * (p + 1) + s, s == STEPS - 1);
        end
        phase = "R5"; readout(1'b1);

        summary();
        $finish;
    end
endmodule